// File: doc/BRIEF.md
# SRAM Bank Initialization Sequencer

This engine prepares parity-protected SRAM banks for use by overwriting every word of the selected banks with an all-zero data word that carries valid parity bits. Later parity checks on read therefore never trip on uninitialized contents. Software selects banks with a six-bit mask and pulses a start input. All selected banks are then swept in parallel by one shared counter that runs for a fixed number of cycles and writes one word per bank per cycle. A bank holding fewer words than the sweep length stops writing once its last word has been written.

While a sweep runs, a bus access that targets a bank under initialization is stalled and proceeds when the sweep ends. Accesses to any other bank pass without delay. A read-only status vector reports which banks have completed initialization. When reset is released, bank 0 is swept automatically without any software action. Parity checking and address-to-bank decoding are outside this block. The bus side presents only a request flag and a bank index.

Top module: `sram_init_seq`

## Requirements
- R1: In the first cycle after reset is released, a sweep of bank 0 is already running (busy high, bank 0 write enable high at address 0) without any start pulse.
- R2: A sweep keeps init_busy_o high for exactly 1024 consecutive cycles.
- R3: In sweep cycle k (k = 0..1023) init_addr_o equals k. When no sweep runs, init_addr_o is 0 and every write enable is low.
- R4: Bank b's write enable (bit b of init_we_o) is high in sweep cycle k only if b is selected and k is below that bank's word count. The default word counts for banks 0..5 are 1024, 1024, 1024, 512, 1024, 640.
- R5: init_wdata_o is 34 bits: bits 31:0 are zero, and bits 33 and 32 are odd-parity bits of data halves [31:16] and [15:0]. Both are therefore 1, so the word is 34'h3_0000_0000.
- R6: On an accepted start, the status bits of the selected banks clear in the next cycle. Unselected status bits keep their value.
- R7: When a sweep ends, the status bits of all banks it covered become 1 in the cycle after its last write cycle, and busy falls in that same cycle.
- R8: bus_stall_o is high exactly when bus_req_i is high and bus_bank_i (0..5) names a bank in the running sweep. Indices 6 and 7 never stall.
- R9: A request held on a swept bank is released in the first cycle after the sweep's last write cycle.
- R10: A start pulse that arrives while a sweep is running is ignored. The mask, the count and the status remain as they were.
- R11: A start pulse with an all-zero mask is ignored and no sweep begins.
- R12: During and directly after reset, init_done_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request to begin a sweep |
| bank_sel_i | input | 6 | Banks to initialize, bit b for bank b |
| bus_req_i | input | 1 | A bus access is presented this cycle |
| bus_bank_i | input | 3 | Bank index of the presented access |
| bus_stall_o | output | 1 | Hold the presented access |
| init_we_o | output | 6 | Per-bank write enable of the sweep |
| init_addr_o | output | 10 | Word address written in all enabled banks |
| init_wdata_o | output | 34 | Fill word: data bits 31:0, parity bits 33:32 |
| init_busy_o | output | 1 | A sweep is running |
| init_done_o | output | 6 | Per-bank initialization complete status |

## Verification
The hardest situations to reach are at the edges of a sweep. One is a start pulse that lands while a sweep is still running. Another is the single cycle at the end of a sweep, when a stalled request must be released just as the status bits rise. The stimulus aims a start at a different mask into the middle of the power-up sweep. It then holds a bank-0 request across the final cycle of a later sweep so that the release cycle can be observed. A background pattern sweeps the bank index over all eight codes, including the two invalid ones, so that stall decisions are compared against the model on every cycle. This covers both short banks and an empty mask.

// File: rtl/sram_init_pkg.sv
package sram_init_pkg;

  // Sequencer phases: waiting for a start, or sweeping the selected banks.
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SWEEP = 1'b1
  } seq_state_e;

endpackage

// File: rtl/sinit_ctrl.sv
module sinit_ctrl
  import sram_init_pkg::*;
#(
  parameter int unsigned NB_BANKS  = 6,
  parameter int unsigned SWEEP_LEN = 1024,
  parameter logic [NB_BANKS-1:0] AUTO_MASK = 1,
  localparam int unsigned CW = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [NB_BANKS-1:0] sel_i,
  output logic                busy_o,
  output logic [CW-1:0]       cnt_o,
  output logic [NB_BANKS-1:0] mask_o,
  output logic [NB_BANKS-1:0] done_o
);

  localparam logic [CW-1:0] LAST_IDX = CW'(SWEEP_LEN - 1);

  seq_state_e          state_q;
  logic [CW-1:0]       cnt_q;
  logic [NB_BANKS-1:0] mask_q;
  logic [NB_BANKS-1:0] done_q;
  logic                last_word;
  logic                accept;

  assign last_word = (cnt_q == LAST_IDX);
  assign accept    = start_i && (sel_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= (AUTO_MASK != '0) ? SEQ_SWEEP : SEQ_IDLE;
      cnt_q   <= '0;
      mask_q  <= AUTO_MASK;
      done_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q <= SEQ_SWEEP;
            cnt_q   <= '0;
            mask_q  <= sel_i;
            done_q  <= done_q & ~sel_i;
          end
        end
        SEQ_SWEEP: begin
          if (last_word) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            mask_q  <= '0;
            done_q  <= done_q | mask_q;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SEQ_SWEEP);
  assign cnt_o  = cnt_q;
  assign mask_o = mask_q;
  assign done_o = done_q;

endmodule

// File: rtl/sinit_wr.sv
module sinit_wr #(
  parameter int unsigned NB_BANKS  = 6,
  parameter int unsigned SWEEP_LEN = 1024,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAR_LANES = 2,
  parameter bit          ODD_PARITY = 1'b1,
  parameter int unsigned BANK_WORDS [NB_BANKS] = '{1024, 1024, 1024, 512, 1024, 640},
  localparam int unsigned CW = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1,
  localparam int unsigned LANE_W = DATA_W / PAR_LANES
) (
  input  logic                        busy_i,
  input  logic [CW-1:0]               cnt_i,
  input  logic [NB_BANKS-1:0]         mask_i,
  output logic [NB_BANKS-1:0]         we_o,
  output logic [CW-1:0]               addr_o,
  output logic [DATA_W+PAR_LANES-1:0] wdata_o
);

  localparam logic [DATA_W-1:0] FILL_DATA = '0;

  logic [PAR_LANES-1:0] fill_par;

  // Per-bank write enables: a bank drops out once its own last word is done.
  for (genvar b = 0; b < NB_BANKS; b++) begin : g_bank
    assign we_o[b] = busy_i && mask_i[b] && (32'(cnt_i) < BANK_WORDS[b]);
  end

  // Parity of the fill word, one bit per data lane.
  for (genvar l = 0; l < PAR_LANES; l++) begin : g_lane
    assign fill_par[l] = (^FILL_DATA[l*LANE_W +: LANE_W]) ^ ODD_PARITY;
  end

  assign addr_o  = cnt_i;
  assign wdata_o = {fill_par, FILL_DATA};

endmodule

// File: rtl/sinit_gate.sv
module sinit_gate #(
  parameter int unsigned NB_BANKS = 6,
  localparam int unsigned BW = (NB_BANKS > 1) ? $clog2(NB_BANKS) : 1
) (
  input  logic                bus_req_i,
  input  logic [BW-1:0]       bus_bank_i,
  input  logic [NB_BANKS-1:0] mask_i,
  output logic                stall_o
);

  always_comb begin
    stall_o = 1'b0;
    if (bus_req_i && (32'(bus_bank_i) < NB_BANKS)) begin
      stall_o = mask_i[bus_bank_i];
    end
  end

endmodule

// File: rtl/sram_init_seq.sv
module sram_init_seq #(
  parameter int unsigned NB_BANKS   = 6,
  parameter int unsigned SWEEP_LEN  = 1024,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PAR_LANES  = 2,
  parameter bit          ODD_PARITY = 1'b1,
  parameter logic [NB_BANKS-1:0] AUTO_MASK = 1,
  parameter int unsigned BANK_WORDS [NB_BANKS] = '{1024, 1024, 1024, 512, 1024, 640},
  localparam int unsigned AW = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1,
  localparam int unsigned BW = (NB_BANKS > 1) ? $clog2(NB_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [NB_BANKS-1:0]         bank_sel_i,
  input  logic                        bus_req_i,
  input  logic [BW-1:0]               bus_bank_i,
  output logic                        bus_stall_o,
  output logic [NB_BANKS-1:0]         init_we_o,
  output logic [AW-1:0]               init_addr_o,
  output logic [DATA_W+PAR_LANES-1:0] init_wdata_o,
  output logic                        init_busy_o,
  output logic [NB_BANKS-1:0]         init_done_o
);

  logic                busy;
  logic [AW-1:0]       cnt;
  logic [NB_BANKS-1:0] mask;

  sinit_ctrl #(
    .NB_BANKS (NB_BANKS),
    .SWEEP_LEN(SWEEP_LEN),
    .AUTO_MASK(AUTO_MASK)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .sel_i  (bank_sel_i),
    .busy_o (busy),
    .cnt_o  (cnt),
    .mask_o (mask),
    .done_o (init_done_o)
  );

  sinit_wr #(
    .NB_BANKS  (NB_BANKS),
    .SWEEP_LEN (SWEEP_LEN),
    .DATA_W    (DATA_W),
    .PAR_LANES (PAR_LANES),
    .ODD_PARITY(ODD_PARITY),
    .BANK_WORDS(BANK_WORDS)
  ) u_wr (
    .busy_i (busy),
    .cnt_i  (cnt),
    .mask_i (mask),
    .we_o   (init_we_o),
    .addr_o (init_addr_o),
    .wdata_o(init_wdata_o)
  );

  sinit_gate #(
    .NB_BANKS(NB_BANKS)
  ) u_gate (
    .bus_req_i (bus_req_i),
    .bus_bank_i(bus_bank_i),
    .mask_i    (mask),
    .stall_o   (bus_stall_o)
  );

  assign init_busy_o = busy;

endmodule

// File: rtl/sram_init_seq_chk.sv
module sram_init_seq_chk #(
  parameter int unsigned NB_BANKS  = 6,
  parameter int unsigned SWEEP_LEN = 1024,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAR_LANES = 2,
  parameter logic [NB_BANKS-1:0] AUTO_MASK = 1,
  localparam int unsigned AW = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1,
  localparam int unsigned BW = (NB_BANKS > 1) ? $clog2(NB_BANKS) : 1
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_req_i,
  input logic [BW-1:0]               bus_bank_i,
  input logic                        bus_stall_o,
  input logic [NB_BANKS-1:0]         init_we_o,
  input logic [AW-1:0]               init_addr_o,
  input logic [DATA_W+PAR_LANES-1:0] init_wdata_o,
  input logic                        init_busy_o,
  input logic [NB_BANKS-1:0]         init_done_o
);

  logic unused_bank;
  assign unused_bank = ^bus_bank_i;

  // R1: a sweep is already running once reset drops
  assert_auto_start_R1: assert property (@(posedge clk)
    (AUTO_MASK != '0) && $fell(rst) |-> init_busy_o);

  // R3: address advances by one each cycle of a sweep
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && init_busy_o && $past(init_busy_o)
      |-> init_addr_o == $past(init_addr_o) + 1'b1);

  // R3: no writes outside a sweep
  assert_we_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (init_we_o != '0) |-> init_busy_o);

  // R5: fill data is zero and never changes
  assert_fill_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (init_we_o != '0) |-> init_wdata_o[DATA_W-1:0] == '0);
  assert_fill_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(init_wdata_o));

  // R7: status bits rise only as a sweep ends
  assert_done_rise_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ((init_done_o & ~$past(init_done_o)) != '0) |-> $fell(init_busy_o));

  // R10: status frozen while a sweep runs
  assert_done_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && init_busy_o && $past(init_busy_o) |-> $stable(init_done_o));

  // R8: a stall needs a request and a running sweep
  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (rst)
    bus_stall_o |-> bus_req_i && init_busy_o);

  // R9: release as the sweep ends
  assert_stall_release_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(init_busy_o) |-> !bus_stall_o);

endmodule

bind sram_init_seq sram_init_seq_chk #(
  .NB_BANKS (NB_BANKS),
  .SWEEP_LEN(SWEEP_LEN),
  .DATA_W   (DATA_W),
  .PAR_LANES(PAR_LANES),
  .AUTO_MASK(AUTO_MASK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_req_i   (bus_req_i),
  .bus_bank_i  (bus_bank_i),
  .bus_stall_o (bus_stall_o),
  .init_we_o   (init_we_o),
  .init_addr_o (init_addr_o),
  .init_wdata_o(init_wdata_o),
  .init_busy_o (init_busy_o),
  .init_done_o (init_done_o)
);

// File: tb/test_sram_init_seq.sv
module test_sram_init_seq;

  localparam int SWEEP = 1024;
  localparam int NB    = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [5:0]  bank_sel_i = '0;
  logic        bus_req_i = 1'b0;
  logic [2:0]  bus_bank_i = '0;
  logic        bus_stall_o;
  logic [5:0]  init_we_o;
  logic [9:0]  init_addr_o;
  logic [33:0] init_wdata_o;
  logic        init_busy_o;
  logic [5:0]  init_done_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int bank_words [NB] = '{1024, 1024, 1024, 512, 1024, 640};

  // reference model state
  bit       m_run;
  int       m_cnt;
  bit [5:0] m_mask;
  bit [5:0] m_done;

  always #10 clk = ~clk;

  sram_init_seq i_sram_init_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .bank_sel_i(bank_sel_i),
    .bus_req_i(bus_req_i), .bus_bank_i(bus_bank_i), .bus_stall_o(bus_stall_o),
    .init_we_o(init_we_o), .init_addr_o(init_addr_o), .init_wdata_o(init_wdata_o),
    .init_busy_o(init_busy_o), .init_done_o(init_done_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_run = 1'b1; m_cnt = 0; m_mask = 6'b000001; m_done = '0;
    end else if (m_run) begin
      if (m_cnt == SWEEP - 1) begin
        m_run = 1'b0; m_cnt = 0; m_done = m_done | m_mask; m_mask = '0;
      end else begin
        m_cnt++;
      end
    end else if (start_i && bank_sel_i != '0) begin
      m_run = 1'b1; m_cnt = 0; m_mask = bank_sel_i; m_done = m_done & ~bank_sel_i;
    end
  end

  // compare against the model every cycle, mid-period
  always @(negedge clk) begin
    if (!rst) begin
      logic [5:0] e_we;
      logic       e_stall;
      for (int b = 0; b < NB; b++)
        e_we[b] = m_run && m_mask[b] && (m_cnt < bank_words[b]);
      e_stall = bus_req_i && (bus_bank_i < 3'd6) && m_mask[bus_bank_i];
      chk("R2", "busy", 64'(init_busy_o), 64'(m_run));
      chk("R3", "addr", 64'(init_addr_o), 64'(m_cnt));
      chk("R4", "we", 64'(init_we_o), 64'(e_we));
      chk("R5", "wdata", 64'(init_wdata_o), 64'h3_0000_0000);
      chk("R6/R7", "done", 64'(init_done_o), 64'(m_done));
      chk("R8", "stall", 64'(bus_stall_o), 64'(e_stall));
    end
  end

  task automatic tick();
    @(posedge clk); #5;
    cyc++;
  endtask

  task automatic traffic();
    bus_req_i  = ((cyc & 1) ^ ((cyc >> 3) & 1)) != 0;
    bus_bank_i = 3'(cyc % 8);
  endtask

  task automatic pulse(input logic [5:0] sel);
    start_i = 1'b1; bank_sel_i = sel;
    tick();
    start_i = 1'b0; bank_sel_i = '0;
  endtask

  task automatic run_out();
    for (int i = 0; i < 3000 && init_busy_o; i++) begin
      traffic();
      tick();
    end
  endtask

  initial begin
    repeat (3) tick();
    chk("R12", "done in reset", 64'(init_done_o), 64'h0);
    rst = 1'b0;
    // R1: first cycle after reset already sweeping bank 0
    chk("R1", "auto busy", 64'(init_busy_o), 64'h1);
    chk("R1", "auto we", 64'(init_we_o), 64'h01);
    chk("R12", "done after reset", 64'(init_done_o), 64'h0);
    repeat (100) begin traffic(); tick(); end
    // R10: start while running is ignored
    pulse(6'b111110);
    chk("R10", "mask kept", 64'(init_we_o), 64'h01);
    run_out();
    chk("R10", "only auto bank done", 64'(init_done_o), 64'h01);
    // R11: empty mask ignored
    pulse(6'b000000);
    chk("R11", "busy after empty start", 64'(init_busy_o), 64'h0);
    // all banks, hold a bank 0 request through the end (R9)
    pulse(6'b111111);
    chk("R6", "all cleared", 64'(init_done_o), 64'h00);
    bus_req_i = 1'b1; bus_bank_i = 3'd0;
    for (int i = 0; i < 3000 && init_busy_o; i++) begin
      tick();
      if (init_busy_o) chk("R9", "held stall", 64'(bus_stall_o), 64'h1);
    end
    #1;
    chk("R9", "released", 64'(bus_stall_o), 64'h0);
    chk("R7", "all done", 64'(init_done_o), 64'h3f);
    // short banks, partial mask
    pulse(6'b101010);
    chk("R6", "partial clear", 64'(init_done_o), 64'h15);
    run_out();
    chk("R7", "partial done", 64'(init_done_o), 64'h3f);
    pulse(6'b000100);
    run_out();
    tick();
    chk("R3", "idle addr", 64'(init_addr_o), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule